// File: doc/BRIEF.md
# CAN Nominal Bit Timing Sequencer

This block turns the protocol engine clock into the time base of a CAN node. A programmable prescaler produces a one-cycle time quantum enable. A segment state machine then steps through every nominal bit, one quantum at a time, in this order: sync, propagation, phase 1, phase 2. It raises a sample pulse at the last quantum of phase 1 and a bit boundary pulse at the last quantum of phase 2. It also holds the receive level that was captured at the sample point.

The receive line is watched for falling (recessive-to-dominant) edges at every quantum. When the caller flags a start of frame, a falling edge forces hard synchronization: the quantum of the edge becomes the sync segment and the bit restarts. Any other falling edge resynchronizes the bit, at most once per bit time:
- An edge before the sample point lengthens phase 1.
- An edge after the sample point shortens phase 2.
- Either correction is limited to the programmed jump width.

The timing fields (prescaler, jump width, both phase segments) are stored as length minus one. They are loaded through a write port that only takes effect in freeze mode. The propagation length comes from a separate input.

States of `cbt_seg_fsm`:
- `SEG_SYNC` (code 0)
- `SEG_PROP` (code 1)
- `SEG_PH1` (code 2)
- `SEG_PH2` (code 3)

Transitions, all taken on a quantum tick:
- SYNC→PROP: always, after one quantum.
- PROP→PH1: when the propagation count is complete.
- PH1→PH2: when the extended phase 1 count is complete; the sample pulse is raised here.
- PH2→SYNC: when the shortened phase 2 count is complete; the bit boundary pulse is raised here.
- any→PROP: hard synchronization.

Top module: `can_bit_timer`

## Requirements
- R1: The quantum enable `tq_en_o` is high for one cycle every `presc`+1 engine clock cycles, where `presc` is the stored 8-bit prescaler value.
- R2: One bit is built from these segments, each counted in quanta:

  | Segment | Length (quanta) |
  |---|---|
  | Sync | 1 |
  | Propagation | `prop_i`+1 |
  | Phase 1 | `ph1`+1 |
  | Phase 2 | `ph2`+1 |

  `sample_o` pulses on the last quantum of phase 1. `bit_end_o` pulses on the last quantum of phase 2. `seg_o` reports the segment as sync=0, propagation=1, phase 1=2, phase 2=3.
- R3: A write on `cfg_we_i` updates the stored prescaler, jump width and phase fields only while `freeze_i` is high. Without `freeze_i`, the write leaves all timing unchanged.
- R4: A phase 2 value of 0 is stored as 1, so phase 2 is never shorter than two quanta.
- R5: `rx_bit_o` takes the value of `rx_i` in the sample quantum and holds it until the next sample. It is 1 after reset.
- R6: A falling edge of `rx_i` seen in the propagation or phase 1 segment lengthens phase 1 by min(e, `rjw`+1) quanta. Here e is the number of quanta from the end of sync up to and including the edge quantum.
- R7: A falling edge in phase 2, at phase 2 quantum index c, shortens phase 2 by min(`ph2`−c, `rjw`+1) quanta. When that amount reaches the full remainder, the bit ends in the edge quantum.
- R8: The following do not change the bit:
  - rising edges;
  - edges seen in the sync segment;
  - a second falling edge within the same bit.
- R9: With `hard_sync_i` high, a falling edge restarts the bit: the edge quantum counts as the sync segment, and propagation begins on the next quantum with no jump width limit.
- R10: After reset, the stored values are: prescaler 0, jump width 0, phase 1 value 3, phase 2 value 3. `seg_o` is sync and `tq_en_o` is high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Protocol engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Freeze mode; enables configuration writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_presc_i | input | 8 | Prescaler value (quantum = value+1 clocks) |
| cfg_rjw_i | input | 2 | Jump width value (width = value+1 quanta) |
| cfg_ph1_i | input | 3 | Phase 1 value (length = value+1 quanta) |
| cfg_ph2_i | input | 3 | Phase 2 value (length = value+1 quanta, 0 taken as 1) |
| prop_i | input | 3 | Propagation value (length = value+1 quanta) |
| hard_sync_i | input | 1 | Treat the next falling edge as hard synchronization |
| rx_i | input | 1 | Receive line, 1 = recessive |
| tq_en_o | output | 1 | Time quantum enable |
| sample_o | output | 1 | Sample point pulse |
| bit_end_o | output | 1 | Bit boundary pulse |
| rx_bit_o | output | 1 | Receive level captured at the sample point |
| seg_o | output | 2 | Current segment code |

## Verification
The embedded properties assume that `prop_i` and the stored phase fields stay constant while a bit is in progress. They also assume that `rx_i` and `hard_sync_i` are only meaningful at quantum ticks. The bench therefore changes configuration only between bits and then lets two bit boundaries pass before it measures anything. It drives `rx_i` and `hard_sync_i` away from the clock edge, and it drops `hard_sync_i` one cycle after the edge it qualifies. Every edge is placed by counting quanta from an observed `bit_end_o`, so the expected sample and boundary positions follow from the segment lengths alone.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int PRESC_W = 8;
    localparam int SEG_W   = 3;
    localparam int RJW_W   = 2;
    localparam int CNT_W   = SEG_W + 1;
    localparam int ERR_W   = CNT_W + 1;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [RJW_W-1:0]   rjw;
        logic [SEG_W-1:0]   ph1;
        logic [SEG_W-1:0]   ph2;
    } timing_cfg_t;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
    import cbt_pkg::*;
#(
    parameter bit CLAMP_PH2 = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freeze_i,
    input  logic               we_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [RJW_W-1:0]   rjw_i,
    input  logic [SEG_W-1:0]   ph1_i,
    input  logic [SEG_W-1:0]   ph2_i,
    output timing_cfg_t        cfg_o
);
    logic [SEG_W-1:0] ph2_w;

    generate
        if (CLAMP_PH2) begin : g_clamp
            assign ph2_w = (ph2_i == '0) ? SEG_W'(1) : ph2_i;
        end else begin : g_raw
            assign ph2_w = ph2_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o.presc <= '0;
            cfg_o.rjw   <= '0;
            cfg_o.ph1   <= SEG_W'(3);
            cfg_o.ph2   <= SEG_W'(3);
        end else if (we_i && freeze_i) begin
            cfg_o.presc <= presc_i;
            cfg_o.rjw   <= rjw_i;
            cfg_o.ph1   <= ph1_i;
            cfg_o.ph2   <= ph2_w;
        end
    end

    // R3: outside freeze a write leaves the stored timing untouched
    a_r3_locked_outside_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && freeze_i) |=> $stable(cfg_o));

    // R4: the stored phase 2 value never falls to zero
    a_r4_ph2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        we_i && freeze_i |=> cfg_o.ph2 != '0);
endmodule

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler
    import cbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tq_en_o
);
    logic [PRESC_W-1:0] cnt_q;

    assign tq_en_o = (cnt_q >= presc_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tq_en_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: each quantum tick restarts the divider
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tq_en_o |=> cnt_q == '0);

    // R1: between ticks the divider advances by exactly one
    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        !tq_en_o |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_en_i,
    input  timing_cfg_t      cfg_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic             hard_sync_i,
    input  logic             rx_i,
    output seg_e             seg_o,
    output logic             sample_o,
    output logic             bit_end_o,
    output logic             rx_bit_o
);
    seg_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ext_q, ext_d;
    logic [CNT_W-1:0] shr_q, shr_d;
    logic             done_q, done_d;
    logic             rx_prev_q;
    logic             rx_bit_q;

    logic             fall;
    logic             hsync;
    logic             resync_ok;
    logic [CNT_W-1:0] jump;
    logic [ERR_W-1:0] err;
    logic [CNT_W-1:0] ext_new, ext_eff;
    logic [CNT_W-1:0] rem, shr_new, shr_eff;
    logic             ph1_end, ph2_end;

    // edge qualification and correction amounts
    always_comb begin
        fall      = tq_en_i && rx_prev_q && !rx_i;
        hsync     = fall && hard_sync_i;
        resync_ok = fall && !hard_sync_i && !done_q && (state_q != SEG_SYNC);
        jump      = CNT_W'(cfg_i.rjw) + 1'b1;

        if (state_q == SEG_PROP) begin
            err = ERR_W'(cnt_q) + 1'b1;
        end else begin
            err = ERR_W'(prop_i) + ERR_W'(cnt_q) + ERR_W'(2);
        end
        ext_new = (err < ERR_W'(jump)) ? CNT_W'(err) : jump;
        ext_eff = (resync_ok && (state_q == SEG_PROP || state_q == SEG_PH1))
                  ? ext_new : ext_q;

        rem     = CNT_W'(cfg_i.ph2) - cnt_q;
        shr_new = (rem < jump) ? rem : jump;
        shr_eff = (resync_ok && state_q == SEG_PH2) ? shr_new : shr_q;

        ph1_end = (cnt_q == CNT_W'(cfg_i.ph1) + ext_eff);
        ph2_end = (cnt_q == CNT_W'(cfg_i.ph2) - shr_eff);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ext_d   = ext_q;
        shr_d   = shr_q;
        done_d  = done_q;
        if (tq_en_i) begin
            if (hsync) begin
                state_d = SEG_PROP;
                cnt_d   = '0;
                ext_d   = '0;
                shr_d   = '0;
                done_d  = 1'b1;
            end else begin
                unique case (state_q)
                    SEG_SYNC: begin
                        state_d = SEG_PROP;
                        cnt_d   = '0;
                        ext_d   = '0;
                        shr_d   = '0;
                        done_d  = fall;
                    end
                    SEG_PROP: begin
                        if (resync_ok) begin
                            ext_d  = ext_new;
                            done_d = 1'b1;
                        end
                        if (cnt_q == CNT_W'(prop_i)) begin
                            state_d = SEG_PH1;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    SEG_PH1: begin
                        if (resync_ok) begin
                            ext_d  = ext_new;
                            done_d = 1'b1;
                        end
                        if (ph1_end) begin
                            state_d = SEG_PH2;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    SEG_PH2: begin
                        if (resync_ok) begin
                            shr_d  = shr_new;
                            done_d = 1'b1;
                        end
                        if (ph2_end) begin
                            state_d = SEG_SYNC;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SEG_SYNC;
            cnt_q     <= '0;
            ext_q     <= '0;
            shr_q     <= '0;
            done_q    <= 1'b0;
            rx_prev_q <= 1'b1;
            rx_bit_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ext_q   <= ext_d;
            shr_q   <= shr_d;
            done_q  <= done_d;
            if (tq_en_i) begin
                rx_prev_q <= rx_i;
            end
            if (sample_o) begin
                rx_bit_q <= rx_i;
            end
        end
    end

    // outputs
    always_comb begin
        seg_o     = state_q;
        sample_o  = tq_en_i && !hsync && (state_q == SEG_PH1) && ph1_end;
        bit_end_o = tq_en_i && !hsync && (state_q == SEG_PH2) && ph2_end;
        rx_bit_o  = rx_bit_q;
    end

    // R2: segments only advance on quantum ticks
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tq_en_i |=> $stable(state_q) && $stable(cnt_q));

    // R2: sync always lasts exactly one quantum
    a_r2_sync_one_tq: assert property (@(posedge clk) disable iff (!rst_n)
        tq_en_i && state_q == SEG_SYNC |=> state_q == SEG_PROP);

    // R2: sample and boundary never coincide
    a_r2_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && bit_end_o));

    // R5: captured bit only changes after a sample
    a_r5_rx_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_o |=> $stable(rx_bit_o));

    // R6: lengthening never exceeds the jump width
    a_r6_ext_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q <= jump);

    // R7: shortening never exceeds the jump width
    a_r7_shr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        shr_q <= jump);

    // R8: once a bit has resynchronized, its phase 1 extension is frozen
    a_r8_single_resync: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && state_q == SEG_PH1 && !hard_sync_i |=> $stable(ext_q));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freeze_i,
    input  logic               cfg_we_i,
    input  logic [PRESC_W-1:0] cfg_presc_i,
    input  logic [RJW_W-1:0]   cfg_rjw_i,
    input  logic [SEG_W-1:0]   cfg_ph1_i,
    input  logic [SEG_W-1:0]   cfg_ph2_i,
    input  logic [SEG_W-1:0]   prop_i,
    input  logic               hard_sync_i,
    input  logic               rx_i,
    output logic               tq_en_o,
    output logic               sample_o,
    output logic               bit_end_o,
    output logic               rx_bit_o,
    output logic [1:0]         seg_o
);
    timing_cfg_t cfg;
    seg_e        seg;

    cbt_cfg_regs #(.CLAMP_PH2(1'b1)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (freeze_i),
        .we_i     (cfg_we_i),
        .presc_i  (cfg_presc_i),
        .rjw_i    (cfg_rjw_i),
        .ph1_i    (cfg_ph1_i),
        .ph2_i    (cfg_ph2_i),
        .cfg_o    (cfg)
    );

    cbt_tq_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .presc_i (cfg.presc),
        .tq_en_o (tq_en_o)
    );

    cbt_seg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tq_en_i     (tq_en_o),
        .cfg_i       (cfg),
        .prop_i      (prop_i),
        .hard_sync_i (hard_sync_i),
        .rx_i        (rx_i),
        .seg_o       (seg),
        .sample_o    (sample_o),
        .bit_end_o   (bit_end_o),
        .rx_bit_o    (rx_bit_o)
    );

    assign seg_o = seg;
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       freeze_i, cfg_we_i, hard_sync_i, rx_i;
    logic [7:0] cfg_presc_i;
    logic [1:0] cfg_rjw_i;
    logic [2:0] cfg_ph1_i, cfg_ph2_i, prop_i;
    logic       tq_en_o, sample_o, bit_end_o, rx_bit_o;
    logic [1:0] seg_o;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .cfg_we_i(cfg_we_i),
        .cfg_presc_i(cfg_presc_i), .cfg_rjw_i(cfg_rjw_i), .cfg_ph1_i(cfg_ph1_i),
        .cfg_ph2_i(cfg_ph2_i), .prop_i(prop_i), .hard_sync_i(hard_sync_i),
        .rx_i(rx_i), .tq_en_o(tq_en_o), .sample_o(sample_o), .bit_end_o(bit_end_o),
        .rx_bit_o(rx_bit_o), .seg_o(seg_o)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) next_cyc();
    endtask

    task automatic wait_bit_end();
        int g = 0;
        do begin
            next_cyc();
            g++;
        end while (!bit_end_o && g < 400);
        if (!bit_end_o) check("R2", "bit_end timeout", 0, 1);
    endtask

    // cycles from the current cycle until sample_o (0 if already high)
    task automatic until_sample(output int n);
        n = 0;
        while (!sample_o && n < 400) begin
            next_cyc();
            n++;
        end
    endtask

    task automatic until_bit_end(output int n);
        n = 0;
        while (!bit_end_o && n < 400) begin
            next_cyc();
            n++;
        end
    endtask

    task automatic cfg_write(bit frz, int p, int r, int a, int b);
        next_cyc();
        freeze_i    = frz;
        cfg_we_i    = 1'b1;
        cfg_presc_i = 8'(p);
        cfg_rjw_i   = 2'(r);
        cfg_ph1_i   = 3'(a);
        cfg_ph2_i   = 3'(b);
        next_cyc();
        cfg_we_i = 1'b0;
        wait_bit_end();
        wait_bit_end();
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        steps(3);
        check("R10", "seg after reset", int'(seg_o), 0);
        check("R10", "tq_en during reset", int'(tq_en_o), 1);
        check("R5", "rx_bit after reset", int'(rx_bit_o), 1);
        rst_n = 1'b1;
        wait_bit_end();
        next_cyc();
        until_bit_end(n);
        check("R10", "default bit length", n + 1, 11);
    endtask

    task automatic t_prescaler();
        int n;
        cfg_write(1'b1, 3, 1, 2, 3);
        while (!tq_en_o) next_cyc();
        n = 0;
        do begin next_cyc(); n++; end while (!tq_en_o && n < 50);
        check("R1", "quantum period presc=3", n, 4);
        cfg_write(1'b0, 7, 1, 2, 3);
        while (!tq_en_o) next_cyc();
        n = 0;
        do begin next_cyc(); n++; end while (!tq_en_o && n < 50);
        check("R3", "presc write outside freeze", n, 4);
        cfg_write(1'b1, 0, 1, 2, 3);
    endtask

    task automatic t_nominal();
        int n;
        wait_bit_end();
        next_cyc();
        check("R2", "seg code sync", int'(seg_o), 0);
        next_cyc();
        check("R2", "seg code prop", int'(seg_o), 1);
        steps(2);
        check("R2", "seg code ph1", int'(seg_o), 2);
        until_sample(n);
        check("R2", "sample offset", n + 4, 6);
        check("R5", "rx_bit captured high", int'(rx_bit_o), 1);
        next_cyc();
        check("R2", "seg code ph2", int'(seg_o), 3);
        until_bit_end(n);
        check("R2", "sample to bit end", n + 1, 4);
    endtask

    task automatic t_edge(string req, int k, bit hs, int exp);
        int n;
        wait_bit_end();
        steps(k);
        rx_i        = 1'b0;
        hard_sync_i = hs;
        #1;
        n = 0;
        while (!sample_o && n < 400) begin
            next_cyc();
            hard_sync_i = 1'b0;
            #1;
            n++;
        end
        hard_sync_i = 1'b0;
        check(req, "sample index after edge", k + n, exp);
        next_cyc();
        check("R5", "rx_bit captured low", int'(rx_bit_o), 0);
        rx_i = 1'b1;
    endtask

    task automatic t_shorten(int rjw, int exp);
        int n;
        cfg_write(1'b1, 0, rjw, 2, 3);
        wait_bit_end();
        until_sample(n);
        next_cyc();
        rx_i = 1'b0;
        #1;
        until_bit_end(n);
        check("R7", "sample to shortened bit end", n + 1, exp);
        next_cyc();
        rx_i = 1'b1;
    endtask

    task automatic t_one_resync();
        int n;
        wait_bit_end();
        steps(2);
        rx_i = 1'b0;
        next_cyc();
        rx_i = 1'b1;
        next_cyc();
        rx_i = 1'b0;
        #1;
        until_sample(n);
        check("R8", "second edge ignored", n + 4, 7);
        next_cyc();
        rx_i = 1'b1;
    endtask

    task automatic t_sync_edge();
        int n;
        wait_bit_end();
        next_cyc();
        rx_i = 1'b0;
        steps(2);
        rx_i = 1'b1;
        #1;
        until_sample(n);
        check("R8", "sync-segment and rising edges ignored", n + 3, 6);
    endtask

    task automatic t_freeze_gate();
        int n;
        cfg_write(1'b0, 0, 1, 5, 3);
        wait_bit_end();
        next_cyc();
        until_sample(n);
        check("R3", "ph1 write outside freeze", n + 1, 6);
    endtask

    task automatic t_ph2_clamp();
        int n;
        cfg_write(1'b1, 0, 1, 2, 0);
        wait_bit_end();
        next_cyc();
        until_sample(n);
        next_cyc();
        until_bit_end(n);
        check("R4", "ph2 zero clamped", n + 1, 2);
        cfg_write(1'b1, 0, 1, 2, 3);
    endtask

    initial begin
        rst_n = 1'b0; freeze_i = 1'b0; cfg_we_i = 1'b0; hard_sync_i = 1'b0;
        rx_i = 1'b1; cfg_presc_i = '0; cfg_rjw_i = '0; cfg_ph1_i = '0;
        cfg_ph2_i = '0; prop_i = 3'd1;
        t_reset();
        t_prescaler();
        t_nominal();
        t_edge("R6", 2, 1'b0, 7);
        t_edge("R6", 3, 1'b0, 8);
        t_edge("R6", 5, 1'b0, 8);
        t_one_resync();
        t_sync_edge();
        t_edge("R9", 5, 1'b1, 10);
        t_shorten(3, 1);
        t_shorten(0, 3);
        cfg_write(1'b1, 0, 1, 2, 3);
        t_freeze_gate();
        freeze_i = 1'b1;
        t_ph2_clamp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule